// File: doc/BRIEF.md
# Sequenced-service watchdog reset timer

This block guards a chip against runaway software. A free-running prescaler divides the system clock by 2^DIV_BITS, which is 32768 by default, and produces a slow watchdog tick. Once the watchdog is enabled, it counts these ticks. If software does not complete a two-step service sequence before a selectable number of ticks has passed, the block pulls an active-low reset request low for a fixed number of system cycles. That request resets the device and anything wired to it. When the request releases, the tick count starts again from zero.

Software configures the block once after reset, through a small write port that carries an enable and a 2-bit rate. Service writes arrive on an 8-bit valid/ready stream. A write is accepted on any cycle where both `svc_valid` and `svc_ready` are high. `svc_ready` is low only while the reset request is being held, and any write offered during that time is not accepted. A producer must keep `svc_valid` and `svc_data` steady until the write is accepted.

Top module: `svc_watchdog`

## Requirements
- R1: While `rst_n` is low, and after it is released, `wdt_rst_n` and `svc_ready` are high. The watchdog stays disabled until a configuration write enables it, so it never expires without one.
- R2: The watchdog tick fires on every system-clock edge whose number, counted from the release of `rst_n`, is a multiple of P = 2^DIV_BITS. No service write and no expiry moves the tick phase.
- R3: With the watchdog enabled at rate code r, it expires on the 4^r-th tick that follows the latest clear. A clear is the configuration write, a completed service, or the end of a reset hold. A tick on the same edge as the clear is not counted.
- R4: Only the first `cfg_we` after reset takes effect. Every later configuration write is ignored.
- R5: Accepting 0x55 and then 0xAA clears the tick count. An accepted 0xAA that does not follow an armed 0x55 has no effect.
- R6: An accepted value other than 0x55 or 0xAA disarms the sequence. Repeating 0x55 keeps the sequence armed.
- R7: When a service completes on the same edge as an expiry would occur, the service wins and no expiry happens.
- R8: After an expiry edge, `wdt_rst_n` and `svc_ready` are low for exactly HOLD_CYC cycles. Service writes offered during that window are ignored.
- R9: When the hold ends, the tick count and the arming state restart from their cleared values.
- R10: A configuration write with the enable bit at 0 keeps the watchdog from ever expiring.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe, honoured once after reset |
| cfg_en | input | 1 | Enable value written with `cfg_we` |
| cfg_rate | input | 2 | Rate code r; the timeout is 4^r ticks |
| svc_valid | input | 1 | Service write offered |
| svc_ready | output | 1 | Service write can be accepted (low during a reset hold) |
| svc_data | input | 8 | Service write value |
| wdt_rst_n | output | 1 | Active-low reset request |

## Verification
Most internal faults in this block show at the ports as a shifted expiry edge. A tick phase that is off by one, a wrong rate decode or a missed clear moves the falling edge of `wdt_rst_n` by at least one tick period. An arming fault makes the service either clear the count too early or fail to clear it. Either way, the next expiry moves by whole ticks, and this is visible within one timeout window. A fault in the hold counter changes the width of the low pulse, or it lets a write offered during the hold change the timing of the following expiry.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam int RATE_W = 2;
  localparam logic [7:0] SVC_ARM  = 8'h55;
  localparam logic [7:0] SVC_FIRE = 8'hAA;

  typedef enum logic {ARM_IDLE = 1'b0, ARM_SET = 1'b1} arm_e;

  typedef struct packed {
    logic              en;
    logic [RATE_W-1:0] rate;
  } wdt_cfg_t;
endpackage

// File: rtl/wdt_prescaler.sv
module wdt_prescaler #(
  parameter int DIV_BITS = 15
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick_o
);
  generate
    if (DIV_BITS == 0) begin : g_nodiv
      assign tick_o = 1'b1;
    end else begin : g_div
      logic [DIV_BITS-1:0] pre_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pre_q <= '0;
        else        pre_q <= pre_q + 1'b1;
      end
      assign tick_o = &pre_q;

      // R2
      tick_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick_o |=> !tick_o);
    end
  endgenerate
endmodule

// File: rtl/wdt_cfg_lock.sv
module wdt_cfg_lock
  import wdt_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     we_i,
  input  wdt_cfg_t cfg_i,
  output wdt_cfg_t cfg_o
);
  logic     locked_q;
  wdt_cfg_t cfg_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      locked_q <= 1'b0;
      cfg_q    <= '0;
    end else if (we_i && !locked_q) begin
      locked_q <= 1'b1;
      cfg_q    <= cfg_i;
    end
  end
  assign cfg_o = cfg_q;

  // R4
  cfg_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    locked_q |=> $stable(cfg_o));
endmodule

// File: rtl/wdt_svc_seq.sv
module wdt_svc_seq
  import wdt_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       flush_i,
  input  logic       acc_i,
  input  logic [7:0] data_i,
  output logic       clr_o
);
  arm_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    if (flush_i) begin
      st_d = ARM_IDLE;
    end else if (acc_i) begin
      if (data_i == SVC_ARM)       st_d = ARM_SET;
      else                         st_d = ARM_IDLE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ARM_IDLE;
    else        st_q <= st_d;
  end

  assign clr_o = acc_i && !flush_i && (data_i == SVC_FIRE) && (st_q == ARM_SET);

  // R5
  fire_disarms_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_o |=> (st_q == ARM_IDLE));
  // R6
  stray_disarms_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_i && data_i != SVC_ARM && data_i != SVC_FIRE) |=> (st_q == ARM_IDLE));
endmodule

// File: rtl/wdt_timeout.sv
module wdt_timeout
  import wdt_pkg::*;
#(
  parameter int STEP = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_i,
  input  logic              en_i,
  input  logic [RATE_W-1:0] rate_i,
  input  logic              clr_i,
  input  logic              hold_i,
  output logic              expire_o
);
  localparam int CNT_W = STEP * ((1 << RATE_W) - 1);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W:0]   lim_full;
  logic [CNT_W-1:0] lim_m1;

  assign lim_full = {{CNT_W{1'b0}}, 1'b1} << (STEP * int'(rate_i));
  assign lim_m1   = CNT_W'(lim_full - 1'b1);

  assign expire_o = en_i && tick_i && !hold_i && !clr_i && (cnt_q == lim_m1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (hold_i || clr_i || !en_i || expire_o) begin
      cnt_q <= '0;
    end else if (tick_i) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  // R9
  hold_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hold_i |=> (cnt_q == '0));
  // R3
  cnt_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    en_i |-> (cnt_q <= lim_m1));
endmodule

// File: rtl/svc_watchdog.sv
module svc_watchdog
  import wdt_pkg::*;
#(
  parameter int DIV_BITS = 15,
  parameter int HOLD_CYC = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic              cfg_en,
  input  logic [RATE_W-1:0] cfg_rate,
  input  logic              svc_valid,
  output logic              svc_ready,
  input  logic [7:0]        svc_data,
  output logic              wdt_rst_n
);
  localparam int HOLD_W = $clog2(HOLD_CYC + 1);

  logic        tick;
  logic        clr;
  logic        expire;
  logic        hold;
  logic        acc;
  wdt_cfg_t    cfg_in, cfg;
  logic [HOLD_W-1:0] hold_q;

  assign cfg_in = '{en: cfg_en, rate: cfg_rate};
  assign hold   = (hold_q != '0);
  assign acc    = svc_valid && svc_ready;

  wdt_prescaler #(.DIV_BITS(DIV_BITS)) u_pre (
    .clk(clk), .rst_n(rst_n), .tick_o(tick));

  wdt_cfg_lock u_cfg (
    .clk(clk), .rst_n(rst_n), .we_i(cfg_we), .cfg_i(cfg_in), .cfg_o(cfg));

  wdt_svc_seq u_seq (
    .clk(clk), .rst_n(rst_n), .flush_i(hold), .acc_i(acc),
    .data_i(svc_data), .clr_o(clr));

  wdt_timeout #(.STEP(2)) u_tmo (
    .clk(clk), .rst_n(rst_n), .tick_i(tick), .en_i(cfg.en),
    .rate_i(cfg.rate), .clr_i(clr), .hold_i(hold), .expire_o(expire));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      hold_q <= '0;
    else if (expire) hold_q <= HOLD_W'(HOLD_CYC);
    else if (hold)   hold_q <= hold_q - 1'b1;
  end

  assign wdt_rst_n = !hold;
  assign svc_ready = !hold;

  // R8
  expire_outside_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    expire |-> wdt_rst_n);
  // R8
  fall_from_expire_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(wdt_rst_n) |-> $past(expire));
  // R7
  clear_blocks_expire_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> wdt_rst_n);
endmodule

// File: tb/test_svc_watchdog.sv
module test_svc_watchdog;
  localparam int DIVB = 2;
  localparam int P    = 1 << DIVB;
  localparam int HOLD = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_we = 1'b0, cfg_en = 1'b0;
  logic [1:0] cfg_rate = 2'd0;
  logic svc_valid = 1'b0;
  logic [7:0] svc_data = 8'h00;
  logic svc_ready, wdt_rst_n;

  int checks = 0, errors = 0;
  logic [8:0] svc_s [0:1023];
  logic [3:0] cfg_s [0:1023];

  always #5 clk = ~clk;

  svc_watchdog #(.DIV_BITS(DIVB), .HOLD_CYC(HOLD)) i_svc_watchdog (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_en(cfg_en),
    .cfg_rate(cfg_rate), .svc_valid(svc_valid), .svc_ready(svc_ready),
    .svc_data(svc_data), .wdt_rst_n(wdt_rst_n));

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic clear_sched();
    for (int i = 0; i < 1024; i++) begin
      svc_s[i] = '0;
      cfg_s[i] = '0;
    end
  endtask

  // f1/f2: edge numbers of the first two falls (0 = none); len1: low cycles of first hold
  task automatic run(input int n, output int f1, output int len1, output int f2,
                     output bit rdy_ok);
    bit prev;
    f1 = 0; f2 = 0; len1 = 0; rdy_ok = 1'b1; prev = 1'b1;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    for (int k = 1; k <= n; k++) begin
      cfg_we    = cfg_s[k][3];
      cfg_en    = cfg_s[k][2];
      cfg_rate  = cfg_s[k][1:0];
      svc_valid = svc_s[k][8];
      svc_data  = svc_s[k][7:0];
      @(posedge clk);
      @(negedge clk);
      if (svc_ready !== wdt_rst_n) rdy_ok = 1'b0;
      if (!wdt_rst_n) begin
        if (prev) begin
          if (f1 == 0) f1 = k;
          else if (f2 == 0) f2 = k;
        end
        if (f2 == 0) len1++;
      end
      prev = wdt_rst_n;
    end
    cfg_we = 1'b0; svc_valid = 1'b0;
  endtask

  function automatic int expect_at(input int clr_edge, input int r);
    return (clr_edge / P + (1 << (2 * r))) * P;
  endfunction

  initial begin
    #(200000 * 10);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int f1, len1, f2, e1, e2;
    bit rok;

    // R1 reset state
    repeat (2) @(negedge clk);
    chk(wdt_rst_n === 1'b1 && svc_ready === 1'b1, "R1 reset outputs", int'(wdt_rst_n), 1);
    clear_sched();
    run(300, f1, len1, f2, rok);
    chk(f1 == 0, "R1 no config no expiry", f1, 0);

    // R3 / R8 / R9: sweep every rate code
    for (int r = 0; r < 4; r++) begin
      clear_sched();
      cfg_s[1] = {1'b1, 1'b1, 2'(r)};
      e1 = expect_at(1, r);
      e2 = expect_at(e1 + HOLD, r);
      run(e2 + 8, f1, len1, f2, rok);
      chk(f1 == e1, $sformatf("R3 rate %0d first expiry", r), f1, e1);
      chk(len1 == HOLD, $sformatf("R8 rate %0d hold length", r), len1, HOLD);
      chk(rok, "R8 ready tracks hold", int'(rok), 1);
      chk(f2 == e2, $sformatf("R9 rate %0d restart expiry", r), f2, e2);
    end

    // R2: tick phase from reset, sweep the enable edge at rate 0
    for (int c = 1; c <= 8; c++) begin
      clear_sched();
      cfg_s[c] = 4'b1100;
      e1 = expect_at(c, 0);
      run(e1 + 3, f1, len1, f2, rok);
      chk(f1 == e1, $sformatf("R2 enable at %0d", c), f1, e1);
    end

    // R5 / R7: sweep the service completion edge at rate 1
    for (int s = 2; s <= 16; s++) begin
      clear_sched();
      cfg_s[1] = 4'b1101;
      svc_s[s-1] = {1'b1, 8'h55};
      svc_s[s]   = {1'b1, 8'hAA};
      e1 = expect_at(s, 1);
      run(e1 + 3, f1, len1, f2, rok);
      chk(f1 == e1, s == 16 ? "R7 service beats expiry" : $sformatf("R5 service at %0d", s),
          f1, e1);
    end

    // R5: lone 0xAA has no effect
    clear_sched();
    cfg_s[1] = 4'b1101;
    svc_s[6] = {1'b1, 8'hAA};
    run(30, f1, len1, f2, rok);
    chk(f1 == 16, "R5 lone AA ignored", f1, 16);

    // R6: stray value disarms
    clear_sched();
    cfg_s[1] = 4'b1101;
    svc_s[5] = {1'b1, 8'h55};
    svc_s[6] = {1'b1, 8'h12};
    svc_s[7] = {1'b1, 8'hAA};
    run(30, f1, len1, f2, rok);
    chk(f1 == 16, "R6 stray disarms", f1, 16);

    // R6: repeated 0x55 stays armed
    clear_sched();
    cfg_s[1] = 4'b1101;
    svc_s[5] = {1'b1, 8'h55};
    svc_s[6] = {1'b1, 8'h55};
    svc_s[7] = {1'b1, 8'hAA};
    run(30, f1, len1, f2, rok);
    chk(f1 == 20, "R6 repeat arm kept", f1, 20);

    // R4: rate rewrite ignored
    clear_sched();
    cfg_s[1] = 4'b1101;
    cfg_s[3] = 4'b1111;
    run(30, f1, len1, f2, rok);
    chk(f1 == 16, "R4 rate locked", f1, 16);

    // R4: enable after disable ignored
    clear_sched();
    cfg_s[1] = 4'b1000;
    cfg_s[2] = 4'b1100;
    run(300, f1, len1, f2, rok);
    chk(f1 == 0, "R4 enable locked", f1, 0);

    // R10: disabled never expires
    clear_sched();
    cfg_s[1] = 4'b1011;
    run(300, f1, len1, f2, rok);
    chk(f1 == 0, "R10 disabled", f1, 0);

    // R8: arm offered during hold is ignored, so the later 0xAA does not clear
    clear_sched();
    cfg_s[1] = 4'b1101;
    svc_s[17] = {1'b1, 8'h55};
    svc_s[25] = {1'b1, 8'hAA};
    run(45, f1, len1, f2, rok);
    chk(f1 == 16, "R8 expiry before hold write", f1, 16);
    chk(f2 == 36, "R8 write during hold ignored", f2, 36);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule